// File: doc/BRIEF.md
# Serial Bit-Entry Word Assembler

This block turns a stream of single-bit entries, each arriving as a one-cycle strobe with a 0 or 1 value, into an 8-bit control word. It suits front panels where a user keys a word in one bit at a time on debounced push buttons. Entered bits shift into a working register. A fill counter tracks how many bits are held.

The output word is kept apart from the working register. A confirm strobe copies the working register to the output only when exactly eight bits have been entered. A successful confirm also raises a one-cycle valid pulse. A cancel strobe, or a confirm made too early, throws the partial entry away and leaves the output as it was. When several strobes arrive in the same cycle, a fixed priority settles them.

Top module: `bitword_assembler`

## Requirements
- R1: While reset is high and after its release, `word_out` is 0x00, `word_valid` is 0 and the fill count is zero.
- R2: Each accepted bit strobe shifts `bit_val` into bit 0 of the working word and moves earlier bits up by one place. After eight entries, the first bit entered sits in bit 7 and the last in bit 0.
- R3: A confirm with exactly eight bits entered updates `word_out` with the assembled word one clock edge after the strobe. On that same cycle `word_valid` is 1, and it is high for exactly one cycle.
- R4: Once eight bits are held, further bit strobes are ignored until a confirm or cancel arrives.
- R5: A confirm made with fewer than eight bits entered drops the partial entry. It does not pulse `word_valid` and leaves `word_out` unchanged.
- R6: A cancel strobe drops the partial or full entry and leaves `word_out` unchanged.
- R7: When cancel and confirm arrive in the same cycle, cancel wins: no valid pulse and no output change, even with eight bits held.
- R8: When confirm and a bit strobe arrive in the same cycle, the confirm is acted on and the bit is not entered into the next word.
- R9: `word_out` changes only on a successful confirm.
- R10: After any confirm or cancel, entry restarts from an empty working word with a fill count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe: enter one bit |
| bit_val | input | 1 | Value of the bit entered with `bit_stb` |
| cancel_stb | input | 1 | One-cycle strobe: discard the current entry |
| confirm_stb | input | 1 | One-cycle strobe: commit the entry if eight bits are held |
| word_out | output | 8 | Last confirmed word, registered |
| word_valid | output | 1 | One-cycle pulse after a successful confirm |

## Verification
Every result is registered once. A strobe applied before rising edge k therefore shows on `word_out` and `word_valid` right after edge k, and the valid pulse is gone after edge k+1. The bench drives each stimulus just after a falling edge and waits for one rising edge. It then compares both outputs at the next falling edge, so each vector's expected values describe exactly the cycle that follows its strobes. Ignored strobes and dropped entries cannot be seen directly at the ports. They are checked through a later confirm, which must either fail to pulse or pulse with the word that only a correct fill count would produce.

// File: rtl/bitword_pkg.sv
package bitword_pkg;

  // Action chosen for one cycle after strobe priority is resolved
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_SHIFT  = 2'd1,
    ACT_COMMIT = 2'd2,
    ACT_DROP   = 2'd3
  } act_t;

endpackage

// File: rtl/bitword_arbiter.sv
module bitword_arbiter
  import bitword_pkg::*;
(
  input  logic bit_stb,
  input  logic cancel_stb,
  input  logic confirm_stb,
  input  logic full,
  output act_t act
);

  // Priority: cancel, then confirm, then bit entry (R7, R8)
  always_comb begin
    if (cancel_stb)               act = ACT_DROP;
    else if (confirm_stb)         act = full ? ACT_COMMIT : ACT_DROP;  // R5
    else if (bit_stb && !full)    act = ACT_SHIFT;                     // R4
    else                          act = ACT_IDLE;
  end

endmodule

// File: rtl/bitword_shifter.sv
module bitword_shifter
  import bitword_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  act_t              act,
  input  logic              bit_val,
  output logic [WORD_W-1:0] work,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic              full
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic clear_w;
  assign clear_w = (act == ACT_COMMIT) || (act == ACT_DROP);
  assign full    = (fill_cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst || clear_w)         fill_cnt <= '0;
    else if (act == ACT_SHIFT)  fill_cnt <= fill_cnt + 1'b1;
  end

  // Shift chain: new bit at position 0, older bits move up (R2)
  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_cell
      logic next_in;
      if (i == 0) begin : g_head
        assign next_in = bit_val;
      end else begin : g_link
        assign next_in = work[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst || clear_w)        work[i] <= 1'b0;
        else if (act == ACT_SHIFT) work[i] <= next_in;
      end
    end
  endgenerate

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_FULL);

  assert_no_shift_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    full |=> fill_cnt == CNT_FULL || fill_cnt == '0);

  assert_restart_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_COMMIT || act == ACT_DROP) |=> (fill_cnt == '0 && work == '0));

endmodule

// File: rtl/bitword_holder.sv
module bitword_holder
  import bitword_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  act_t              act,
  input  logic [WORD_W-1:0] work,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= (act == ACT_COMMIT);
      if (act == ACT_COMMIT) word_out <= work;
    end
  end

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_COMMIT) |=> $stable(word_out));

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

endmodule

// File: rtl/bitword_assembler.sv
module bitword_assembler
  import bitword_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              cancel_stb,
  input  logic              confirm_stb,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  act_t              act;
  logic              full;
  logic [WORD_W-1:0] work;
  logic [CNT_W-1:0]  fill_cnt;

  bitword_arbiter u_arb (
    .bit_stb     (bit_stb),
    .cancel_stb  (cancel_stb),
    .confirm_stb (confirm_stb),
    .full        (full),
    .act         (act)
  );

  bitword_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .bit_val  (bit_val),
    .work     (work),
    .fill_cnt (fill_cnt),
    .full     (full)
  );

  bitword_holder #(.WORD_W(WORD_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .work       (work),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

  assert_short_confirm_R5: assert property (@(posedge clk) disable iff (rst)
    (confirm_stb && !full) |=> (!word_valid && $stable(word_out)));

  assert_cancel_wins_R6_R7: assert property (@(posedge clk) disable iff (rst)
    cancel_stb |=> (!word_valid && $stable(word_out)));

  assert_full_confirm_R3: assert property (@(posedge clk) disable iff (rst)
    (confirm_stb && !cancel_stb && full) |=> (word_valid && word_out == $past(work)));

  assert_confirm_beats_bit_R8: assert property (@(posedge clk) disable iff (rst)
    (confirm_stb && bit_stb && !cancel_stb) |=> fill_cnt == '0);

endmodule

// File: tb/bitword_assembler_test.sv
module bitword_assembler_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_stb = 1'b0, bit_val = 1'b0, cancel_stb = 1'b0, confirm_stb = 1'b0;
  logic [7:0] word_out;
  logic       word_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bitword_assembler uut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .cancel_stb(cancel_stb), .confirm_stb(confirm_stb),
    .word_out(word_out), .word_valid(word_valid)
  );

  // Vector: {req, strobes {bit_stb,bit_val,cancel,confirm}, exp_valid, exp_word}
  localparam int NV = 57;
  localparam logic [16:0] VEC [NV] = '{
    // R2: enter 1,0,1,1,0,0,1,0 -> 0xB2
    {4'd2,4'b1100,1'b0,8'h00}, {4'd2,4'b1000,1'b0,8'h00},
    {4'd2,4'b1100,1'b0,8'h00}, {4'd2,4'b1100,1'b0,8'h00},
    {4'd2,4'b1000,1'b0,8'h00}, {4'd2,4'b1000,1'b0,8'h00},
    {4'd2,4'b1100,1'b0,8'h00}, {4'd2,4'b1000,1'b0,8'h00},
    // R3: confirm, one-cycle pulse
    {4'd3,4'b0001,1'b1,8'hB2}, {4'd3,4'b0000,1'b0,8'hB2},
    // R5: three bits then early confirm
    {4'd5,4'b1100,1'b0,8'hB2}, {4'd5,4'b1100,1'b0,8'hB2},
    {4'd5,4'b1100,1'b0,8'hB2}, {4'd5,4'b0001,1'b0,8'hB2},
    // R4: 0,1,0,1,0,1,0,1 then an extra 1 that must be ignored -> 0x55
    {4'd4,4'b1000,1'b0,8'hB2}, {4'd4,4'b1100,1'b0,8'hB2},
    {4'd4,4'b1000,1'b0,8'hB2}, {4'd4,4'b1100,1'b0,8'hB2},
    {4'd4,4'b1000,1'b0,8'hB2}, {4'd4,4'b1100,1'b0,8'hB2},
    {4'd4,4'b1000,1'b0,8'hB2}, {4'd4,4'b1100,1'b0,8'hB2},
    {4'd4,4'b1100,1'b0,8'hB2}, {4'd4,4'b0001,1'b1,8'h55},
    {4'd9,4'b0000,1'b0,8'h55},
    // R6: four bits then cancel
    {4'd6,4'b1100,1'b0,8'h55}, {4'd6,4'b1100,1'b0,8'h55},
    {4'd6,4'b1100,1'b0,8'h55}, {4'd6,4'b1100,1'b0,8'h55},
    {4'd6,4'b0010,1'b0,8'h55},
    // R7: full 0x0F then cancel+confirm together
    {4'd7,4'b1000,1'b0,8'h55}, {4'd7,4'b1000,1'b0,8'h55},
    {4'd7,4'b1000,1'b0,8'h55}, {4'd7,4'b1000,1'b0,8'h55},
    {4'd7,4'b1100,1'b0,8'h55}, {4'd7,4'b1100,1'b0,8'h55},
    {4'd7,4'b1100,1'b0,8'h55}, {4'd7,4'b1100,1'b0,8'h55},
    {4'd7,4'b0011,1'b0,8'h55},
    // R8: 1,1,0,0,1,1,0,0 then confirm with a bit strobe -> 0xCC
    {4'd8,4'b1100,1'b0,8'h55}, {4'd8,4'b1100,1'b0,8'h55},
    {4'd8,4'b1000,1'b0,8'h55}, {4'd8,4'b1000,1'b0,8'h55},
    {4'd8,4'b1100,1'b0,8'h55}, {4'd8,4'b1100,1'b0,8'h55},
    {4'd8,4'b1000,1'b0,8'h55}, {4'd8,4'b1000,1'b0,8'h55},
    {4'd8,4'b1101,1'b1,8'hCC},
    // R8/R10: seven bits then confirm must be short (strobed bit was not kept)
    {4'd8,4'b1100,1'b0,8'hCC}, {4'd8,4'b1100,1'b0,8'hCC},
    {4'd8,4'b1100,1'b0,8'hCC}, {4'd8,4'b1100,1'b0,8'hCC},
    {4'd8,4'b1100,1'b0,8'hCC}, {4'd8,4'b1100,1'b0,8'hCC},
    {4'd8,4'b1100,1'b0,8'hCC}, {4'd10,4'b0001,1'b0,8'hCC},
    {4'd9,4'b0000,1'b0,8'hCC}
  };

  task automatic check(input int req, input logic ev, input logic [7:0] ew);
    checks++;
    if (word_valid !== ev || word_out !== ew) begin
      errors++;
      $display("FAIL R%0d: got valid=%0b word=%02h, expected valid=%0b word=%02h",
               req, word_valid, word_out, ev, ew);
    end
  endtask

  // Drive strobes after a falling edge, sample after the next falling edge
  task automatic step(input logic s, input logic v, input logic c, input logic f);
    bit_stb = s; bit_val = v; cancel_stb = c; confirm_stb = f;
    @(posedge clk);
    @(negedge clk);
    bit_stb = 1'b0; bit_val = 1'b0; cancel_stb = 1'b0; confirm_stb = 1'b0;
  endtask

  task automatic enter_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) step(1'b1, b[k], 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(1, 1'b0, 8'h00);  // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 8'h00);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
      check(int'(VEC[i][16:13]), VEC[i][8], VEC[i][7:0]);
    end

    // R1: reset mid-entry clears output and fill count
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(1, 1'b0, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 8'h00);
    enter_byte(8'hA5);
    check(9, 1'b0, 8'h00);          // R9: nothing shown before confirm
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check(10, 1'b1, 8'hA5);         // R10: reset left a zero fill count
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(3, 1'b0, 8'hA5);          // R3: pulse lasts one cycle

    // R4: confirm with cancel-free full register twice in a row; second is short
    enter_byte(8'h3C);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check(4, 1'b1, 8'h3C);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check(5, 1'b0, 8'h3C);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule